// File: doc/BRIEF.md
# Hardware Page Table Walker

This block services translation-buffer misses without software help. When the translation buffer misses, the requester presents the 26-bit virtual page number and the kind of access (load, store or instruction fetch). The walker forms the address of the matching entry in a single-level, directly indexed page table. The address is a base register value plus the page number times four, because each entry sits in its own 32-bit word. The walker then issues one read on a simple memory port and waits for the response.

The fetched word holds a 22-bit physical frame number in bits 21:0 and four status bits: present (bit 22), store allowed (bit 23), fetch allowed (bit 24) and dirty (bit 25). A present entry that allows the requested access is written into the translation buffer as a one-cycle refill, and the access can then retry. Two cases raise a one-cycle page-fault exception instead: an entry that is not present, and an access the entry's permissions forbid. On a fault, the page number and a cause code are latched for the exception handler. A busy output stalls the requester from the accepted miss until the walker is idle again.

Top module: `ptwalk_top`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are 0, and `fault_cause` is 2'b00.
- R2: When a miss is accepted while idle, the next cycle shows `mem_req_valid`=1 with `mem_req_addr` = (`pt_base` + `miss_vpn`*4) mod 2^32, where `pt_base` is sampled with the miss.
- R3: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request and its address stay unchanged. Exactly one read handshake happens per walk.
- R4: When a response arrives whose bit 22 is 1 and whose permissions allow the access, `fill_valid` is 1 for exactly the next cycle. In that cycle `fill_vpn` is the missed page, `fill_pfn` is bits 21:0 of the response, `fill_store_ok` is bit 23 and `fill_dirty` is bit 25. `fault_valid` stays 0.
- R5: When a response arrives whose bit 22 is 0, `fault_valid` is 1 for exactly the next cycle. `fault_cause` becomes 2'b01 and `fault_vpn` becomes the missed page. `fill_valid` stays 0.
- R6: Access kind is encoded on `miss_kind` as 2'b00 load, 2'b01 store and 2'b10 fetch. A store to a present entry with bit 23 = 0, or a fetch from a present entry with bit 24 = 0, faults with `fault_cause` 2'b10. A load never faults on permissions.
- R7: A not-present entry reports cause 2'b01 whatever its permission bits and the access kind.
- R8: `busy` is 1 from the cycle after the miss is accepted through the refill or fault cycle, and is 0 in the cycle after that. Misses presented while busy are ignored.
- R9: `fault_vpn` and `fault_cause` keep their values until the next fault, including across later refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pt_base | input | 32 | Page table base address |
| miss_valid | input | 1 | Translation miss request |
| miss_vpn | input | 26 | Virtual page number that missed |
| miss_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch |
| busy | output | 1 | Walk in progress, requester must stall |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the page table entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Page table entry word |
| fill_valid | output | 1 | One-cycle translation buffer refill |
| fill_vpn | output | 26 | Page number being refilled |
| fill_pfn | output | 22 | Physical frame number |
| fill_store_ok | output | 1 | Entry allows stores |
| fill_dirty | output | 1 | Entry dirty bit |
| fault_valid | output | 1 | One-cycle page-fault exception |
| fault_vpn | output | 26 | Latched faulting page number |
| fault_cause | output | 2 | Latched cause: 01 not present, 10 protection |

## Verification
The request and its address are due one cycle after the edge that accepts the miss. The refill or fault pulse is due one cycle after the edge that takes the response, and `busy` drops one cycle after that. The bench drives stimulus and samples outputs on falling edges. It counts edges explicitly: it samples the request at the first falling edge after acceptance and the result at the first falling edge after the response. It samples idle at the next falling edge. Memory ready and response latencies are varied so the checks also show that the request is held and that outputs wait for data rather than fixed time.

// File: rtl/ptwalk_pkg.sv
package ptwalk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_FILL  = 3'd3,
    ST_FAULT = 3'd4
  } walk_state_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10
  } acc_kind_t;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_ABSENT  = 2'b01,
    CAUSE_PROTECT = 2'b10
  } fault_cause_t;
endpackage

// File: rtl/ptwalk_addr_gen.sv
module ptwalk_addr_gen #(
  parameter int VPN_W   = 26,
  parameter int ADDR_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = ADDR_W'(vpn) << SHIFT_W;
    addr   = base + offset;
  end
endmodule

// File: rtl/ptwalk_entry_check.sv
module ptwalk_entry_check
  import ptwalk_pkg::*;
#(
  parameter int PFN_W  = 22,
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] entry,
  input  logic [1:0]        kind,
  output logic              fill_ok,
  output logic [1:0]        cause
);
  localparam int PresentBit = PFN_W;
  localparam int StoreBit   = PFN_W + 1;
  localparam int FetchBit   = PFN_W + 2;

  logic denied;

  always_comb begin
    unique case (kind)
      ACC_STORE: denied = !entry[StoreBit];
      ACC_FETCH: denied = !entry[FetchBit];
      default:   denied = 1'b0;
    endcase
    if (!entry[PresentBit]) begin
      fill_ok = 1'b0;
      cause   = CAUSE_ABSENT;
    end else if (denied) begin
      fill_ok = 1'b0;
      cause   = CAUSE_PROTECT;
    end else begin
      fill_ok = 1'b1;
      cause   = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/ptwalk_fsm.sv
module ptwalk_fsm
  import ptwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        miss_valid,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  logic        entry_ok,
  output walk_state_t state,
  output logic        accept,
  output logic        take_rsp
);
  walk_state_t nxt;

  always_comb begin
    accept   = (state == ST_IDLE) && miss_valid;
    take_rsp = (state == ST_WAIT) && mem_rsp_valid;
    nxt      = state;
    unique case (state)
      ST_IDLE:  if (miss_valid) nxt = ST_ISSUE;
      ST_ISSUE: if (mem_req_ready) nxt = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) nxt = entry_ok ? ST_FILL : ST_FAULT;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/ptwalk_top.sv
module ptwalk_top
  import ptwalk_pkg::*;
#(
  parameter int VPN_W   = 26,
  parameter int PFN_W   = 22,
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int SHIFT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] pt_base,
  input  logic              miss_valid,
  input  logic [VPN_W-1:0]  miss_vpn,
  input  logic [1:0]        miss_kind,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              fill_valid,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [PFN_W-1:0]  fill_pfn,
  output logic              fill_store_ok,
  output logic              fill_dirty,
  output logic              fault_valid,
  output logic [VPN_W-1:0]  fault_vpn,
  output logic [1:0]        fault_cause
);
  localparam int StoreBit = PFN_W + 1;
  localparam int DirtyBit = PFN_W + 3;

  walk_state_t       state;
  logic              accept, take_rsp, entry_ok;
  logic [1:0]        entry_cause;
  logic [ADDR_W-1:0] addr_calc;
  logic [VPN_W-1:0]  vpn_q;
  logic [1:0]        kind_q;

  ptwalk_addr_gen #(.VPN_W(VPN_W), .ADDR_W(ADDR_W), .SHIFT_W(SHIFT_W)) i_addr (
    .base(pt_base), .vpn(miss_vpn), .addr(addr_calc)
  );

  ptwalk_entry_check #(.PFN_W(PFN_W), .WORD_W(WORD_W)) i_check (
    .entry(mem_rsp_data), .kind(kind_q), .fill_ok(entry_ok), .cause(entry_cause)
  );

  ptwalk_fsm i_fsm (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .entry_ok(entry_ok), .state(state),
    .accept(accept), .take_rsp(take_rsp)
  );

  always_comb begin
    busy          = (state != ST_IDLE);
    mem_req_valid = (state == ST_ISSUE);
    fill_valid    = (state == ST_FILL);
    fault_valid   = (state == ST_FAULT);
    fill_vpn      = vpn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vpn_q         <= '0;
      kind_q        <= ACC_LOAD;
      mem_req_addr  <= '0;
      fill_pfn      <= '0;
      fill_store_ok <= 1'b0;
      fill_dirty    <= 1'b0;
      fault_vpn     <= '0;
      fault_cause   <= CAUSE_NONE;
    end else begin
      if (accept) begin
        vpn_q        <= miss_vpn;
        kind_q       <= miss_kind;
        mem_req_addr <= addr_calc;
      end
      if (take_rsp) begin
        if (entry_ok) begin
          fill_pfn      <= mem_rsp_data[PFN_W-1:0];
          fill_store_ok <= mem_rsp_data[StoreBit];
          fill_dirty    <= mem_rsp_data[DirtyBit];
        end else begin
          fault_vpn   <= vpn_q;
          fault_cause <= entry_cause;
        end
      end
    end
  end
endmodule

// File: rtl/ptwalk_chk.sv
module ptwalk_chk #(
  parameter int VPN_W  = 26,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              fill_valid,
  input logic              fault_valid,
  input logic [1:0]        fault_cause
);
  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R3
  one_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);
  // R4
  fill_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !fill_valid && !busy);
  // R5
  fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid && !busy);
  // R4
  fill_xor_fault_chk: assert property (@(posedge clk) disable iff (rst)
    !(fill_valid && fault_valid));
  // R6
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (fault_cause == 2'b01 || fault_cause == 2'b10));
  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fault_valid && !$past(rst) |-> $stable(fault_cause));
endmodule

bind ptwalk_top ptwalk_chk #(.VPN_W(VPN_W), .ADDR_W(ADDR_W)) i_ptwalk_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .fill_valid(fill_valid), .fault_valid(fault_valid), .fault_cause(fault_cause)
);

// File: tb/test_ptwalk_top.sv
`timescale 1ns/1ps
module test_ptwalk_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pt_base = '0;
  logic        miss_valid = 1'b0;
  logic [25:0] miss_vpn = '0;
  logic [1:0]  miss_kind = 2'b00;
  logic        busy, mem_req_valid, fill_valid, fill_store_ok, fill_dirty, fault_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [31:0] mem_req_addr;
  logic [25:0] fill_vpn, fault_vpn;
  logic [21:0] fill_pfn;
  logic [1:0]  fault_cause;

  int checks = 0;
  int failures = 0;
  int handshakes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptwalk_top i_ptwalk_top (
    .clk(clk), .rst(rst), .pt_base(pt_base), .miss_valid(miss_valid),
    .miss_vpn(miss_vpn), .miss_kind(miss_kind), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_store_ok(fill_store_ok), .fill_dirty(fill_dirty),
    .fault_valid(fault_valid), .fault_vpn(fault_vpn), .fault_cause(fault_cause)
  );

  always @(posedge clk) if (mem_req_valid && mem_req_ready) handshakes++;

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_entry(input bit p, input bit w, input bit x,
                                           input bit d, input logic [21:0] pfn);
    return {6'b0, d, x, w, p, pfn};
  endfunction

  // Runs a walk; is_fill says which result the requirements predict.
  task automatic walk(input string req, input logic [31:0] base, input logic [25:0] vpn,
                      input logic [1:0] kind, input logic [31:0] entry,
                      input int ready_wait, input int rsp_wait,
                      input bit is_fill, input logic [1:0] exp_cause, input bit poke);
    int hs0;
    logic [31:0] exp_addr;
    exp_addr = base + {4'b0, vpn, 2'b00};
    hs0 = handshakes;
    @(negedge clk);
    pt_base = base; miss_vpn = vpn; miss_kind = kind; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R2", "req_valid", mem_req_valid, 1);
    chk("R2", "req_addr", mem_req_addr, exp_addr);
    chk("R8", "busy_after_accept", busy, 1);
    for (int i = 0; i < ready_wait; i++) begin
      if (poke) begin miss_valid = 1'b1; miss_vpn = ~vpn; pt_base = ~base; end
      @(negedge clk);
      miss_valid = 1'b0;
      chk("R3", "req_held", mem_req_valid, 1);
      chk("R3", "addr_held", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    for (int i = 0; i < rsp_wait; i++) begin
      @(negedge clk);
      chk("R8", "busy_waiting", busy, 1);
      chk("R4", "no_early_fill", fill_valid | fault_valid, 0);
    end
    mem_rsp_valid = 1'b1; mem_rsp_data = entry;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    chk("R8", "busy_result", busy, 1);
    chk("R3", "one_handshake", handshakes - hs0, 1);
    if (is_fill) begin
      chk("R4", "fill_valid", fill_valid, 1);
      chk("R4", "no_fault", fault_valid, 0);
      chk("R4", "fill_vpn", fill_vpn, vpn);
      chk("R4", "fill_pfn", fill_pfn, entry[21:0]);
      chk("R4", "fill_store_ok", fill_store_ok, entry[23]);
      chk("R4", "fill_dirty", fill_dirty, entry[25]);
    end else begin
      chk(req, "fault_valid", fault_valid, 1);
      chk(req, "no_fill", fill_valid, 0);
      chk(req, "fault_vpn", fault_vpn, vpn);
      chk(req, "fault_cause", fault_cause, exp_cause);
    end
    @(negedge clk);
    chk("R8", "idle_after", busy, 0);
    chk("R4", "pulse_end", fill_valid | fault_valid, 0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "busy", busy, 0);
    chk("R1", "req_valid", mem_req_valid, 0);
    chk("R1", "fill_valid", fill_valid, 0);
    chk("R1", "fault_valid", fault_valid, 0);
    chk("R1", "fault_cause", fault_cause, 2'b00);
  endtask

  task automatic t_fill_cases();
    walk("R4", 32'h0010_0000, 26'h000_0005, 2'b00, mk_entry(1, 0, 0, 1, 22'h2A_BCDE), 0, 0, 1, 2'b00, 0);
    walk("R4", 32'h8000_0004, 26'h3FF_FFFF, 2'b01, mk_entry(1, 1, 0, 0, 22'h3F_FFFF), 3, 2, 1, 2'b00, 0);
    walk("R6", 32'h0000_0000, 26'h123_4567, 2'b10, mk_entry(1, 0, 1, 0, 22'h00_0001), 1, 4, 1, 2'b00, 0);
  endtask

  task automatic t_not_present();
    walk("R5", 32'h0040_0000, 26'h0AB_CDEF, 2'b00, mk_entry(0, 1, 1, 1, 22'h11_1111), 0, 1, 0, 2'b01, 0);
  endtask

  task automatic t_protect();
    walk("R6", 32'h0002_0000, 26'h000_0100, 2'b01, mk_entry(1, 0, 1, 1, 22'h00_0100), 2, 0, 0, 2'b10, 0);
    walk("R6", 32'h0002_0000, 26'h000_0200, 2'b10, mk_entry(1, 1, 0, 0, 22'h00_0200), 0, 0, 0, 2'b10, 0);
  endtask

  task automatic t_priority();
    walk("R7", 32'h0003_0000, 26'h000_0300, 2'b01, mk_entry(0, 0, 0, 0, 22'h00_0300), 0, 0, 0, 2'b01, 0);
    walk("R7", 32'h0003_0000, 26'h000_0301, 2'b10, mk_entry(0, 0, 0, 1, 22'h00_0301), 1, 1, 0, 2'b01, 0);
  endtask

  task automatic t_ignore_busy();
    walk("R8", 32'h0500_0000, 26'h0F0_F0F0, 2'b00, mk_entry(1, 1, 1, 0, 22'h05_5555), 3, 1, 1, 2'b00, 1);
  endtask

  task automatic t_hold_fault();
    walk("R5", 32'h0, 26'h000_0777, 2'b00, mk_entry(0, 0, 0, 0, 22'h0), 0, 0, 0, 2'b01, 0);
    walk("R9", 32'h0, 26'h000_0888, 2'b00, mk_entry(1, 0, 0, 0, 22'h00_0888), 0, 0, 1, 2'b00, 0);
    repeat (2) @(negedge clk);
    chk("R9", "fault_vpn_held", fault_vpn, 26'h000_0777);
    chk("R9", "fault_cause_held", fault_cause, 2'b01);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fill_cases();
        t_not_present();
        t_protect();
        t_priority();
        t_ignore_busy();
        t_hold_fault();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule